// File: doc/BRIEF.md
# Oversampled Type B frame receiver

This block recovers reader-to-card frames of the ISO 14443 Type B air interface from a one-bit sample stream that arrives at four samples per bit period, each sample qualified by a valid strobe. It looks for a start-of-frame made of a long run of zero bits followed by a rising edge. It then collects ten-bit characters (start bit, eight data bits, stop bit) and hands each good data byte to a byte-write port together with its position in the frame. The frame is closed by an all-zero character.

Frame validity rests on timing rather than on a bare start-bit search. The zero run of the start-of-frame must be long enough but not too long, and the idle gap before each character is bounded. A character with bad framing, an overlong frame and any timing violation all drop the block back to hunting, with a one-cycle error pulse. Checksum checking and response generation belong to the logic that consumes the byte port.

Top module: `rxb_frame_rx`

## Requirements
- R1: Only clock cycles with `smp_valid` high carry a sample; the others change no state and no output. Every output is registered and changes on the clock edge that takes the sample causing it. Each bit lasts four samples, and the bit value is the third sample of each group, with groups counted from the sample that entered the state.
- R2: While hunting, a low sample starts a start-of-frame run and clears `byte_count` to 0; high samples leave the block hunting.
- R3: During the start-of-frame run, a high bit value that follows 10 or more zero bit values is accepted and raises `sync_active`. A high bit value after fewer zero bits pulses `rx_error` and returns to hunting.
- R4: The 13th consecutive zero bit value in the start-of-frame run pulses `rx_error` and returns to hunting; a run of 12 zero bits followed by a high bit is still accepted.
- R5: While waiting for a character, up to 25 consecutive high samples are tolerated and the 26th pulses `rx_error` and returns to hunting; a low sample starts a character and its own four-sample bit group.
- R6: A character is ten bit values. The first is the start bit and must be 0, the tenth is the stop bit and must be 1, and bits two to nine are the data byte, least significant bit first. A good character gives a one-cycle `wr_en` with `wr_data` set to the byte and `wr_index` set to the number of bytes accepted before it in the frame.
- R7: A character of ten zero bit values ends the frame and returns to hunting without an error. `frame_done` pulses for one cycle only when at least one byte was accepted in the frame.
- R8: `byte_count` equals the number of bytes accepted in the current frame, is still valid in the cycle of `frame_done`, and reads 0 in the cycle after it.
- R9: A character that is neither good nor all zeros pulses `rx_error` and returns to hunting.
- R10: The byte write that brings `byte_count` to `MAX_BYTES` pulses `rx_error` in the same cycle as `wr_en`, and the block returns to hunting.
- R11: `sync_active` is high from the accepted start-of-frame until the frame ends through the end character or any error, and is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Qualifies `smp_bit` as one line sample |
| smp_bit | input | 1 | Line sample |
| wr_en | output | 1 | One-cycle strobe for a received byte |
| wr_data | output | 8 | Received data byte |
| wr_index | output | IDX_W | Position of the byte within the frame |
| byte_count | output | CNT_W | Bytes accepted in the current frame |
| frame_done | output | 1 | One-cycle pulse when a non-empty frame ends correctly |
| sync_active | output | 1 | High while a frame is being received |
| rx_error | output | 1 | One-cycle pulse on any timing, framing or length violation |

## Verification
The last byte that fills the frame is written and flagged as an overflow on one clock edge, so `wr_en` and `rx_error` rise together while `sync_active` falls. The bench builds the receiver with a frame limit of four bytes and sends four good characters. A behavioural model compares every output on every clock, and a counter of cycles in which write and error coincide must read exactly one, with no `frame_done`. The end-of-frame decision and the `byte_count` clear on the next edge form a second adjacent pair, which is checked on every clock.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_SOF  = 2'd1,
      ST_GAP  = 2'd2,
      ST_CHAR = 2'd3
   } rx_state_t;

   localparam int CHAR_BITS = 10;
   localparam int DATA_BITS = 8;

endpackage

// File: rtl/rxb_phase.sv
module rxb_phase #(
   parameter int OVERSAMPLE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic at_mid
);
   localparam int PW = $clog2(OVERSAMPLE);
   localparam logic [PW-1:0] MID_PH = PW'(OVERSAMPLE / 2 - 1);
   localparam bit POW2 = ((OVERSAMPLE & (OVERSAMPLE - 1)) == 0);

   logic [PW-1:0] ph;
   logic [PW-1:0] ph_inc;

   generate
      if (OVERSAMPLE < 2) begin : g_bad_os
         $error("rxb_phase: OVERSAMPLE must be at least 2");
      end
      if (POW2) begin : g_wrap
         assign ph_inc = ph + PW'(1);
      end else begin : g_cmp
         localparam logic [PW-1:0] LAST_PH = PW'(OVERSAMPLE - 1);
         assign ph_inc = (ph == LAST_PH) ? '0 : ph + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= '0;
      end else if (clr) begin
         ph <= '0;
      end else if (adv) begin
         ph <= ph_inc;
      end
   end

   assign at_mid = (ph == MID_PH);

endmodule

// File: rtl/rxb_run_timer.sv
module rxb_run_timer #(
   parameter int ZERO_MIN = 10,
   parameter int ZERO_MAX = 12,
   parameter int GAP_MAX  = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic z_clr,
   input  logic z_inc,
   input  logic g_clr,
   input  logic g_inc,
   output logic z_enough,
   output logic z_limit,
   output logic g_limit
);
   localparam int ZW = $clog2(ZERO_MAX + 2);
   localparam int GW = $clog2(GAP_MAX + 2);

   logic [ZW-1:0] zcnt;
   logic [GW-1:0] gcnt;

   generate
      if (ZERO_MIN < 1 || ZERO_MIN > ZERO_MAX) begin : g_bad_zero
         $error("rxb_run_timer: need 1 <= ZERO_MIN <= ZERO_MAX");
      end
      if (GAP_MAX < 1) begin : g_bad_gap
         $error("rxb_run_timer: GAP_MAX must be at least 1");
      end
   endgenerate

   // zero-bit run length of the start-of-frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zcnt <= '0;
      end else if (z_clr) begin
         zcnt <= '0;
      end else if (z_inc && zcnt <= ZW'(ZERO_MAX)) begin
         zcnt <= zcnt + ZW'(1);
      end
   end

   // high samples spent waiting for a start bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gcnt <= '0;
      end else if (g_clr) begin
         gcnt <= '0;
      end else if (g_inc && gcnt <= GW'(GAP_MAX)) begin
         gcnt <= gcnt + GW'(1);
      end
   end

   assign z_enough = (zcnt >= ZW'(ZERO_MIN));
   assign z_limit  = (zcnt >= ZW'(ZERO_MAX));
   assign g_limit  = (gcnt >= GW'(GAP_MAX));

endmodule

// File: rtl/rxb_char_shift.sv
module rxb_char_shift
   import rxb_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 shift,
   input  logic                 bit_in,
   output logic                 last_slot,
   output logic                 good,
   output logic                 eof,
   output logic [DATA_BITS-1:0] data
);
   localparam int BW = $clog2(CHAR_BITS);

   logic [CHAR_BITS-2:0] sh;
   logic [CHAR_BITS-1:0] nxt;
   logic [BW-1:0]        bcnt;

   // newest bit enters at the top, older bits move toward bit 0
   assign nxt = {bit_in, sh};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         bcnt <= '0;
      end else if (clr) begin
         sh   <= '0;
         bcnt <= '0;
      end else if (shift) begin
         sh   <= nxt[CHAR_BITS-1:1];
         bcnt <= bcnt + BW'(1);
      end
   end

   assign last_slot = (bcnt == BW'(CHAR_BITS - 1));
   assign good      = nxt[CHAR_BITS-1] & ~nxt[0];
   assign eof       = (nxt == '0);
   assign data      = nxt[DATA_BITS:1];

endmodule

// File: rtl/rxb_frame_rx.sv
module rxb_frame_rx
   import rxb_pkg::*;
#(
   parameter int MAX_BYTES     = 256,
   parameter int OVERSAMPLE    = 4,
   parameter int SOF_MIN_ZEROS = 10,
   parameter int SOF_MAX_ZEROS = 12,
   parameter int GAP_MAX       = 25,
   localparam int IDX_W = $clog2(MAX_BYTES),
   localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_valid,
   input  logic                 smp_bit,
   output logic                 wr_en,
   output logic [DATA_BITS-1:0] wr_data,
   output logic [IDX_W-1:0]     wr_index,
   output logic [CNT_W-1:0]     byte_count,
   output logic                 frame_done,
   output logic                 sync_active,
   output logic                 rx_error
);
   generate
      if (MAX_BYTES < 2) begin : g_bad_max
         $error("rxb_frame_rx: MAX_BYTES must be at least 2");
      end
   endgenerate

   rx_state_t st, st_n;

   logic ph_clr, ph_adv, at_mid;
   logic z_clr, z_inc, g_clr, g_inc;
   logic z_enough, z_limit, g_limit;
   logic ch_clr, ch_shift, ch_last, ch_good, ch_eof;
   logic [DATA_BITS-1:0] ch_data;
   logic wr_n, err_n, done_n, cnt_clr, cnt_inc, cnt_full;
   logic smp_mid;

   rxb_phase #(.OVERSAMPLE(OVERSAMPLE)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ph_clr),
      .adv    (ph_adv),
      .at_mid (at_mid)
   );

   rxb_run_timer #(
      .ZERO_MIN (SOF_MIN_ZEROS),
      .ZERO_MAX (SOF_MAX_ZEROS),
      .GAP_MAX  (GAP_MAX)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .z_clr    (z_clr),
      .z_inc    (z_inc),
      .g_clr    (g_clr),
      .g_inc    (g_inc),
      .z_enough (z_enough),
      .z_limit  (z_limit),
      .g_limit  (g_limit)
   );

   rxb_char_shift u_char (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ch_clr),
      .shift     (ch_shift),
      .bit_in    (smp_bit),
      .last_slot (ch_last),
      .good      (ch_good),
      .eof       (ch_eof),
      .data      (ch_data)
   );

   assign smp_mid  = smp_valid & at_mid;
   assign cnt_full = (byte_count == CNT_W'(MAX_BYTES - 1));

   always_comb begin
      st_n     = st;
      ph_clr   = 1'b0;
      ph_adv   = 1'b0;
      z_clr    = 1'b0;
      z_inc    = 1'b0;
      g_clr    = 1'b0;
      g_inc    = 1'b0;
      ch_clr   = 1'b0;
      ch_shift = 1'b0;
      wr_n     = 1'b0;
      err_n    = 1'b0;
      done_n   = 1'b0;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      if (smp_valid) begin
         case (st)
            ST_HUNT: begin
               if (!smp_bit) begin
                  st_n    = ST_SOF;
                  ph_clr  = 1'b1;
                  z_clr   = 1'b1;
                  cnt_clr = 1'b1;
               end
            end
            ST_SOF: begin
               ph_adv = 1'b1;
               if (smp_mid) begin
                  if (smp_bit) begin
                     if (z_enough) begin
                        st_n  = ST_GAP;
                        g_clr = 1'b1;
                     end else begin
                        st_n  = ST_HUNT;
                        err_n = 1'b1;
                     end
                  end else begin
                     z_inc = 1'b1;
                     if (z_limit) begin
                        st_n  = ST_HUNT;
                        err_n = 1'b1;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (smp_bit) begin
                  g_inc = 1'b1;
                  if (g_limit) begin
                     st_n  = ST_HUNT;
                     err_n = 1'b1;
                  end
               end else begin
                  st_n   = ST_CHAR;
                  ph_clr = 1'b1;
                  ch_clr = 1'b1;
               end
            end
            ST_CHAR: begin
               ph_adv = 1'b1;
               if (smp_mid) begin
                  ch_shift = 1'b1;
                  if (ch_last) begin
                     if (ch_good) begin
                        wr_n    = 1'b1;
                        cnt_inc = 1'b1;
                        if (cnt_full) begin
                           st_n  = ST_HUNT;
                           err_n = 1'b1;
                        end else begin
                           st_n  = ST_GAP;
                           g_clr = 1'b1;
                        end
                     end else if (ch_eof) begin
                        st_n   = ST_HUNT;
                        done_n = (byte_count != '0);
                     end else begin
                        st_n  = ST_HUNT;
                        err_n = 1'b1;
                     end
                  end
               end
            end
            default: st_n = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_HUNT;
      end else begin
         st <= st_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_count <= '0;
      end else if (cnt_clr || frame_done) begin
         byte_count <= '0;
      end else if (cnt_inc) begin
         byte_count <= byte_count + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en      <= 1'b0;
         wr_data    <= '0;
         wr_index   <= '0;
         frame_done <= 1'b0;
         rx_error   <= 1'b0;
      end else begin
         wr_en      <= wr_n;
         frame_done <= done_n;
         rx_error   <= err_n;
         if (wr_n) begin
            wr_data  <= ch_data;
            wr_index <= byte_count[IDX_W-1:0];
         end
      end
   end

   assign sync_active = (st == ST_GAP) || (st == ST_CHAR);

endmodule

// File: rtl/rxb_frame_rx_chk.sv
module rxb_frame_rx_chk #(
   parameter int MAX_BYTES = 256,
   localparam int IDX_W = $clog2(MAX_BYTES),
   localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_index,
   input logic [CNT_W-1:0] byte_count,
   input logic             frame_done,
   input logic             sync_active,
   input logic             rx_error
);
   // R6
   wr_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> byte_count == CNT_W'(wr_index) + CNT_W'(1));

   // R7
   done_needs_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> byte_count != '0);

   // R7
   done_excl_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !rx_error);

   // R8
   count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> byte_count == '0);

   // R11
   sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done || rx_error) |-> !sync_active);

   // R10
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_count <= CNT_W'(MAX_BYTES));

   // R10
   overflow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && byte_count == CNT_W'(MAX_BYTES)) |-> rx_error);

endmodule

bind rxb_frame_rx rxb_frame_rx_chk #(.MAX_BYTES(MAX_BYTES)) u_rxb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_index    (wr_index),
   .byte_count  (byte_count),
   .frame_done  (frame_done),
   .sync_active (sync_active),
   .rx_error    (rx_error)
);

// File: tb/test_rxb_frame_rx.sv
`timescale 1ns/1ps
module test_rxb_frame_rx;
   localparam int MAXB  = 4;
   localparam int IDXW  = $clog2(MAXB);
   localparam int CNTW  = $clog2(MAXB + 1);

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            smp_valid = 1'b0;
   logic            smp_bit = 1'b1;
   logic            wr_en;
   logic [7:0]      wr_data;
   logic [IDXW-1:0] wr_index;
   logic [CNTW-1:0] byte_count;
   logic            frame_done;
   logic            sync_active;
   logic            rx_error;

   rxb_frame_rx #(.MAX_BYTES(MAXB)) i_rxb_frame_rx (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bit(smp_bit),
      .wr_en(wr_en), .wr_data(wr_data), .wr_index(wr_index),
      .byte_count(byte_count), .frame_done(frame_done),
      .sync_active(sync_active), .rx_error(rx_error));

   int n_cmp = 0;
   int n_bad = 0;
   bit mon_on = 0;
   bit stall = 0;

   task automatic chk(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int   m_st = 0, m_pos = 0, m_zeros = 0, m_gap = 0, m_cnt = 0, m_idx = 0;
   bit   m_q[$];
   bit   m_wr = 0, m_done = 0, m_err = 0, m_allz = 0;
   logic [7:0] m_data = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_wr = 0; m_done = 0; m_err = 0;
      end else begin
         if (m_done) m_cnt = 0;
         m_wr = 0; m_done = 0; m_err = 0;
         if (smp_valid) begin
            case (m_st)
               0: if (!smp_bit) begin
                     m_st = 1; m_pos = 0; m_zeros = 0; m_cnt = 0;
                  end
               1: begin
                     m_pos = (m_pos + 1) % 4;
                     if (m_pos == 2) begin
                        if (smp_bit) begin
                           if (m_zeros >= 10) begin m_st = 2; m_gap = 0; end
                           else begin m_st = 0; m_err = 1; end
                        end else begin
                           m_zeros++;
                           if (m_zeros > 12) begin m_st = 0; m_err = 1; end
                        end
                     end
                  end
               2: if (smp_bit) begin
                     m_gap++;
                     if (m_gap > 25) begin m_st = 0; m_err = 1; end
                  end else begin
                     m_st = 3; m_pos = 0; m_q.delete();
                  end
               default: begin
                     m_pos = (m_pos + 1) % 4;
                     if (m_pos == 2) begin
                        m_q.push_back(smp_bit);
                        if (m_q.size() == 10) begin
                           m_allz = 1;
                           foreach (m_q[i]) if (m_q[i]) m_allz = 0;
                           if (!m_q[0] && m_q[9]) begin
                              for (int i = 0; i < 8; i++) m_data[i] = m_q[i+1];
                              m_wr = 1; m_idx = m_cnt; m_cnt++;
                              if (m_cnt >= MAXB) begin m_st = 0; m_err = 1; end
                              else begin m_st = 2; m_gap = 0; end
                           end else if (m_allz) begin
                              m_st = 0;
                              if (m_cnt != 0) m_done = 1;
                           end else begin
                              m_st = 0; m_err = 1;
                           end
                        end
                     end
                  end
            endcase
         end
      end
   end

   // ---------------- monitor, compared every clock ----------------
   int  n_done = 0, n_errs = 0, n_both = 0, n_rise = 0, done_cnt = 0;
   bit  prev_sync = 0;
   logic [7:0] got_q[$];

   always @(negedge clk) begin
      if (mon_on) begin
         chk("R6 wr_en", int'(wr_en), int'(m_wr));
         if (m_wr) begin
            chk("R6 wr_data", int'(wr_data), int'(m_data));
            chk("R6 wr_index", int'(wr_index), m_idx);
         end
         chk("R8 byte_count", int'(byte_count), m_cnt);
         chk("R7 frame_done", int'(frame_done), int'(m_done));
         chk("R11 sync_active", int'(sync_active), int'(m_st == 2 || m_st == 3));
         chk("R9 rx_error", int'(rx_error), int'(m_err));
         if (wr_en) got_q.push_back(wr_data);
         if (frame_done) begin n_done++; done_cnt = int'(byte_count); end
         if (rx_error) n_errs++;
         if (wr_en && rx_error) n_both++;
         if (sync_active && !prev_sync) n_rise++;
         prev_sync = sync_active;
      end
   end

   // ---------------- stimulus ----------------
   task automatic smp(input logic b);
      if (stall) begin
         @(negedge clk); smp_valid = 1'b0; smp_bit = ~b;
      end
      @(negedge clk); smp_valid = 1'b1; smp_bit = b;
   endtask

   task automatic bits(input logic b, input int n);
      repeat (n) smp(b);
   endtask

   task automatic sof(input int k);
      bits(1'b0, 4 * k);
      bits(1'b1, 3);
   endtask

   task automatic chr10(input logic [9:0] w);
      for (int i = 0; i < 10; i++) bits(w[i], (i == 9) ? 3 : 4);
   endtask

   task automatic chr(input logic [7:0] b);
      chr10({1'b1, b, 1'b0});
   endtask

   task automatic finish_run();
      @(negedge clk); smp_valid = 1'b0;
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   int d0, e0, b0, r0;
   task automatic snap();
      d0 = n_done; e0 = n_errs; b0 = n_both; r0 = n_rise;
      got_q.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1: actual hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R8 reset byte_count", int'(byte_count), 0);
      chk("R11 reset sync_active", int'(sync_active), 0);
      chk("R7 reset frame_done", int'(frame_done), 0);
      chk("R9 reset rx_error", int'(rx_error), 0);
      chk("R6 reset wr_en", int'(wr_en), 0);
      rst_n = 1'b1; mon_on = 1;
      bits(1'b1, 10);

      // R6 R7 R8: three bytes, normal frame
      snap();
      sof(10); bits(1'b1, 4); chr(8'hA5); bits(1'b1, 2); chr(8'h00); chr(8'hFF);
      bits(1'b1, 3); chr10(10'h000); bits(1'b1, 20);
      chk("R7 done pulses", n_done - d0, 1);
      chk("R9 no error", n_errs - e0, 0);
      chk("R3 sync rose", n_rise - r0, 1);
      chk("R6 bytes", got_q.size(), 3);
      if (got_q.size() == 3) begin
         chk("R6 byte0", int'(got_q[0]), 'hA5);
         chk("R6 byte1", int'(got_q[1]), 'h00);
         chk("R6 byte2", int'(got_q[2]), 'hFF);
      end
      chk("R8 count at done", done_cnt, 3);
      chk("R8 count cleared", int'(byte_count), 0);

      // R1: invalid cycles with inverted bits between samples
      stall = 1; snap();
      sof(10); bits(1'b1, 5); chr(8'h3C); chr(8'hC3); chr10(10'h000); bits(1'b1, 10);
      stall = 0; bits(1'b1, 5);
      chk("R1 stalled frame done", n_done - d0, 1);
      chk("R1 stalled bytes", got_q.size(), 2);
      if (got_q.size() == 2) begin
         chk("R1 stalled byte0", int'(got_q[0]), 'h3C);
         chk("R1 stalled byte1", int'(got_q[1]), 'hC3);
      end

      // R3: nine zero bits is too short
      snap(); sof(9); bits(1'b1, 20);
      chk("R3 short sof error", n_errs - e0, 1);
      chk("R3 short sof no sync", n_rise - r0, 0);

      // R4: twelve zero bits still accepted
      snap(); sof(12); bits(1'b1, 2); chr(8'h5A); chr10(10'h000); bits(1'b1, 20);
      chk("R4 twelve zeros done", n_done - d0, 1);
      chk("R4 twelve zeros no error", n_errs - e0, 0);

      // R4: thirteen zero bits abandoned
      snap(); bits(1'b0, 52); bits(1'b1, 23);
      chk("R4 long sof error", int'(n_errs - e0 >= 1), 1);
      chk("R4 long sof no sync", n_rise - r0, 0);

      // R5: 25 idle samples tolerated
      snap(); sof(10); bits(1'b1, 25); chr(8'h81); bits(1'b1, 25); chr10(10'h000);
      bits(1'b1, 20);
      chk("R5 gap 25 done", n_done - d0, 1);
      chk("R5 gap 25 no error", n_errs - e0, 0);

      // R5: 26 idle samples fail
      snap(); sof(10); chr(8'h11); bits(1'b1, 26); bits(1'b1, 10);
      chk("R5 gap 26 error", n_errs - e0, 1);
      chk("R5 gap 26 no done", n_done - d0, 0);

      // R9: stop bit low on a non-zero character
      snap(); sof(10); chr(8'h12); chr10({1'b0, 8'h55, 1'b0}); bits(1'b1, 20);
      chk("R9 framing error", n_errs - e0, 1);
      chk("R9 framing no done", n_done - d0, 0);
      chk("R9 byte before error", got_q.size(), 1);
      chk("R8 count held after error", int'(byte_count), 1);

      // R2 R7: empty frame, count cleared by new start
      snap(); sof(10);
      chk("R2 count cleared by sof", int'(byte_count), 0);
      bits(1'b1, 3); chr10(10'h000); bits(1'b1, 20);
      chk("R7 empty frame no done", n_done - d0, 0);
      chk("R7 empty frame no error", n_errs - e0, 0);
      chk("R11 sync dropped", int'(sync_active), 0);

      // R10: fourth byte overflows the frame
      snap(); sof(10); chr(8'h01); chr(8'h02); chr(8'h03); chr(8'h04); bits(1'b1, 20);
      chk("R10 write with error", n_both - b0, 1);
      chk("R10 overflow error count", n_errs - e0, 1);
      chk("R10 overflow no done", n_done - d0, 0);
      chk("R10 bytes written", got_q.size(), 4);

      finish_run();
   end

endmodule